// File: doc/BRIEF.md
# Multiplexed Seven-Segment Scan Driver

This block drives a bank of eight multiplexed LED digits from an eight-entry display memory. Digits are lit one at a time, in ascending order, with a short dark gap between strobes. While a digit is lit, the block puts out its one-hot strobe together with eight segment lines, a through g plus the decimal point. The segment pattern comes from that digit's memory entry.

A two-bit format input sets how every entry is read. In raw mode the entry drives the segments directly. In hexadecimal mode the low nibble is drawn as 0-9 and A-F. In Code B mode the low nibble is drawn as a numeral, a minus sign, E, H, L, P or blank. The scan only advances on clock cycles where the scan tick input is high, so the tick rate sets the refresh rate.

A shutdown input turns off every output and freezes the scan where it stands. The memory write port still works during shutdown. The outputs are logical "on" signals, and a parameter inverts both output groups for the opposite display polarity.

Top module: `seg_scan_driver`

## Requirements
- R1: While reset is asserted, every digit strobe and segment line is off (all zero with default polarity).
- R2: At most one digit strobe is on at any time. Strobes come in ascending digit order and wrap from digit 7 back to digit 0, starting from digit 0 after reset.
- R3: Each strobe stays on for exactly DWELL_TICKS scan ticks, which is DWELL_TICKS cycles when the tick input is held high.
- R4: Between two strobes there are exactly BLANK_TICKS ticks with all strobes and all segment lines off.
- R5: Segment output bits are ordered {dp,g,f,e,d,c,b,a}, with bit 7 the decimal point. With format 2'b00 or 2'b11 (raw), entry bits 6..0 drive segments a,b,c,e,g,f,d respectively, and a 1 lights the segment. Entry bit 7 lights the decimal point when it is 0.
- R6: With format 2'b01 (hex), the low nibble 0..15 is shown as 0-9, A, b, C, d, E, F. The patterns are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71 in gfedcba order.
- R7: With format 2'b10 (Code B), nibbles 0..9 are shown as numerals. Nibbles 10..15 are shown as minus (40), E (79), H (76), L (38), P (73) and blank (00), and the strobe stays on for a blank digit.
- R8: In the decoded formats, entry bit 7 = 1 lights the decimal point, and entry bits 6..4 have no effect.
- R9: From the first cycle after shutdown is sampled high, all strobes and segments are off and the scan position is held. After shutdown is released, the scan resumes the same digit.
- R10: Memory writes made during shutdown are stored and shown once the scan resumes.
- R11: While the scan tick is low, the active strobe does not change.
- R12: A memory write is visible on the outputs no later than two cycles after the write cycle when its digit is being strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Scan enable tick; the scan timers count only in cycles where it is high |
| wr_en_i | input | 1 | Display memory write enable |
| wr_addr_i | input | 3 | Digit entry to write |
| wr_data_i | input | 8 | Entry value |
| fmt_i | input | 2 | Display format: 00/11 raw, 01 hex, 10 Code B |
| shdn_i | input | 1 | Shutdown: outputs off, scan frozen |
| dig_o | output | 8 | One-hot digit strobes |
| seg_o | output | 8 | Segment lines {dp,g,f,e,d,c,b,a} |

## Verification
The hardest case to reach is shutdown in the middle of a strobe, followed by a resume. The scan must come back on the digit it left, and it must show data that was written while the outputs were dark. The bench waits until a chosen digit has just started its strobe and raises shutdown on that cycle. It then rewrites that digit's entry while the outputs are off. After it releases shutdown, it expects the first lit cycle to belong to the same digit and to carry the new pattern. The bench reaches a frozen tick mid-strobe the same way, and it measures strobe and gap lengths across the wrap from digit 7 to digit 0.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

  typedef enum logic [1:0] {
    FMT_RAW     = 2'b00,
    FMT_HEX     = 2'b01,
    FMT_CODEB   = 2'b10,
    FMT_RAW_ALT = 2'b11
  } fmt_e;

  // Glyphs are returned as {g,f,e,d,c,b,a}.
  function automatic logic [6:0] hex_glyph(input logic [3:0] nib);
    logic [6:0] g;
    case (nib)
      4'h0: g = 7'h3F;
      4'h1: g = 7'h06;
      4'h2: g = 7'h5B;
      4'h3: g = 7'h4F;
      4'h4: g = 7'h66;
      4'h5: g = 7'h6D;
      4'h6: g = 7'h7D;
      4'h7: g = 7'h07;
      4'h8: g = 7'h7F;
      4'h9: g = 7'h6F;
      4'hA: g = 7'h77;
      4'hB: g = 7'h7C;
      4'hC: g = 7'h39;
      4'hD: g = 7'h5E;
      4'hE: g = 7'h79;
      default: g = 7'h71;
    endcase
    return g;
  endfunction

  function automatic logic [6:0] codeb_glyph(input logic [3:0] nib);
    logic [6:0] g;
    case (nib)
      4'hA: g = 7'h40;
      4'hB: g = 7'h79;
      4'hC: g = 7'h76;
      4'hD: g = 7'h38;
      4'hE: g = 7'h73;
      4'hF: g = 7'h00;
      default: g = hex_glyph(nib);
    endcase
    return g;
  endfunction

endpackage

// File: rtl/seg_scan_mem.sv
module seg_scan_mem #(
  parameter int NUM_DIGITS = 8,
  parameter int DATA_W     = 8,
  localparam int IDX_W     = $clog2(NUM_DIGITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0] mem_q [NUM_DIGITS];

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_entry
    logic wr_hit;
    assign wr_hit = wr_en_i && (wr_addr_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[i] <= '0;
      end else if (wr_hit) begin
        mem_q[i] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/seg_scan_decode.sv
module seg_scan_decode
  import seg_scan_pkg::*;
(
  input  fmt_e       fmt_i,
  input  logic [7:0] data_i,
  output logic [7:0] seg_o   // {dp,g,f,e,d,c,b,a}
);

  always_comb begin
    unique case (fmt_i)
      FMT_HEX:   seg_o = {data_i[7], hex_glyph(data_i[3:0])};
      FMT_CODEB: seg_o = {data_i[7], codeb_glyph(data_i[3:0])};
      default: begin
        // raw: bit7 dp (low = lit), bits 6..0 = a,b,c,e,g,f,d
        seg_o = {~data_i[7], data_i[2], data_i[1], data_i[3],
                 data_i[0], data_i[4], data_i[5], data_i[6]};
      end
    endcase
  end

endmodule

// File: rtl/seg_scan_timer.sv
module seg_scan_timer #(
  parameter int NUM_DIGITS  = 8,
  parameter int DWELL_TICKS = 16,
  parameter int BLANK_TICKS = 2,
  localparam int IDX_W      = $clog2(NUM_DIGITS),
  localparam int CNT_MAX    = (DWELL_TICKS > BLANK_TICKS) ? DWELL_TICKS : BLANK_TICKS,
  localparam int CNT_W      = $clog2(CNT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hold_i,
  output logic             show_o,
  output logic [IDX_W-1:0] digit_o
);

  localparam logic [CNT_W-1:0] LAST_SHOW  = CNT_W'(DWELL_TICKS - 1);
  localparam logic [CNT_W-1:0] LAST_BLANK = CNT_W'(BLANK_TICKS - 1);

  logic             show_q, show_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] digit_q, digit_d, digit_inc;
  logic             step;

  if ((1 << IDX_W) == NUM_DIGITS) begin : g_wrap_pow2
    assign digit_inc = IDX_W'(digit_q + 1'b1);
  end else begin : g_wrap_cmp
    assign digit_inc = (digit_q == IDX_W'(NUM_DIGITS - 1)) ? '0 : IDX_W'(digit_q + 1'b1);
  end

  assign step = tick_i && !hold_i;

  always_comb begin
    show_d  = show_q;
    cnt_d   = cnt_q;
    digit_d = digit_q;
    if (step) begin
      if (show_q) begin
        if (cnt_q == LAST_SHOW) begin
          show_d  = 1'b0;
          cnt_d   = '0;
          digit_d = digit_inc;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (cnt_q == LAST_BLANK) begin
        show_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      show_q  <= 1'b0;
      cnt_q   <= '0;
      digit_q <= '0;
    end else begin
      show_q  <= show_d;
      cnt_q   <= cnt_d;
      digit_q <= digit_d;
    end
  end

  assign show_o  = show_q;
  assign digit_o = digit_q;

  // R2: the digit index moves only at the end of a strobe
  a_r2_advance_on_strobe_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digit_q != $past(digit_q)) |-> ($past(show_q) && !show_q));

  // R3: the phase counter stays within the dwell window while showing
  a_r3_dwell_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    show_q |-> (cnt_q <= LAST_SHOW));

  // R9: shutdown freezes the scan state
  a_r9_hold_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> ($stable(digit_q) && $stable(cnt_q) && $stable(show_q)));

  // R11: no tick, no movement
  a_r11_tick_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(digit_q) && $stable(show_q)));

endmodule

// File: rtl/seg_scan_driver.sv
module seg_scan_driver
  import seg_scan_pkg::*;
#(
  parameter int NUM_DIGITS  = 8,
  parameter int DWELL_TICKS = 16,
  parameter int BLANK_TICKS = 2,
  parameter bit ACTIVE_LOW  = 1'b0,
  localparam int IDX_W      = $clog2(NUM_DIGITS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic [1:0]            fmt_i,
  input  logic                  shdn_i,
  output logic [NUM_DIGITS-1:0] dig_o,
  output logic [7:0]            seg_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  logic             show;
  logic [IDX_W-1:0] digit;
  logic [7:0]       entry;
  logic [7:0]       glyph;

  seg_scan_timer #(
    .NUM_DIGITS  (NUM_DIGITS),
    .DWELL_TICKS (DWELL_TICKS),
    .BLANK_TICKS (BLANK_TICKS)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .tick_i  (tick_i),
    .hold_i  (shdn_i),
    .show_o  (show),
    .digit_o (digit)
  );

  seg_scan_mem #(
    .NUM_DIGITS (NUM_DIGITS),
    .DATA_W     (8)
  ) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (digit),
    .rd_data_o (entry)
  );

  seg_scan_decode u_dec (
    .fmt_i  (fmt_e'(fmt_i)),
    .data_i (entry),
    .seg_o  (glyph)
  );

  logic [NUM_DIGITS-1:0] dig_d, dig_q;
  logic [7:0]            seg_d, seg_q;
  logic                  drive;

  assign drive = show && !shdn_i;

  always_comb begin
    dig_d = '0;
    seg_d = '0;
    if (drive) begin
      dig_d[digit] = 1'b1;
      seg_d        = glyph;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      dig_q <= '0;
      seg_q <= '0;
    end else begin
      dig_q <= dig_d;
      seg_q <= seg_d;
    end
  end

  assign dig_o = dig_q ^ {NUM_DIGITS{ACTIVE_LOW}};
  assign seg_o = seg_q ^ {8{ACTIVE_LOW}};

  // R2: never more than one strobe
  a_r2_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(dig_q));

  // R4: segments are dark whenever no digit is strobed
  a_r4_dark_gap: assert property (@(posedge clk_i) disable iff (!rst_n)
    (dig_q == '0) |-> (seg_q == '0));

  // R9: shutdown darkens the outputs on the next cycle
  a_r9_shutdown_dark: assert property (@(posedge clk_i) disable iff (!rst_n)
    shdn_i |=> ((dig_q == '0) && (seg_q == '0)));

endmodule

// File: tb/tb_seg_scan_driver.sv
module tb_seg_scan_driver;

  localparam int CLK_PERIOD = 10;
  localparam int DWELL      = 16;
  localparam int BLANK      = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] fmt;
  logic       shdn;
  logic [7:0] dig;
  logic [7:0] seg;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  seg_scan_driver #(
    .NUM_DIGITS  (8),
    .DWELL_TICKS (DWELL),
    .BLANK_TICKS (BLANK),
    .ACTIVE_LOW  (1'b0)
  ) dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .fmt_i     (fmt),
    .shdn_i    (shdn),
    .dig_o     (dig),
    .seg_o     (seg)
  );

  function automatic logic [7:0] exp_raw(input logic [7:0] d);
    return {~d[7], d[2], d[1], d[3], d[0], d[4], d[5], d[6]};
  endfunction

  function automatic logic [6:0] exp_hex(input logic [3:0] n);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[n];
  endfunction

  function automatic logic [6:0] exp_codeb(input logic [3:0] n);
    logic [6:0] t [6] = '{7'h40, 7'h79, 7'h76, 7'h38, 7'h73, 7'h00};
    return (n < 4'd10) ? exp_hex(n) : t[n - 4'd10];
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // returns at the negedge where strobe d is first seen
  task automatic wait_digit(input int d, output logic [7:0] s);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (dig == (8'b1 << d)) begin
        s = seg;
        return;
      end
    end
    checks++; errors++;
    $display("FAIL R2: strobe for digit %0d not seen, actual %h expected %h", d, dig, 8'b1 << d);
    s = 8'hxx;
  endtask

  task automatic test_reset();
    rst_n = 1'b0; tick = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    fmt = 2'b00; shdn = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 strobes in reset", dig, 8'h00);
    check("R1 segments in reset", seg, 8'h00);
    rst_n = 1'b1;
  endtask

  task automatic test_raw();
    logic [7:0] pat [8] = '{8'h00, 8'h7F, 8'hC0, 8'hA0, 8'h90, 8'h88, 8'h84, 8'h82};
    logic [7:0] s;
    fmt = 2'b00;
    for (int i = 0; i < 8; i++) wr(3'(i), pat[i]);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      wait_digit(i, s);
      check($sformatf("R5 raw digit %0d", i), s, exp_raw(pat[i]));
    end
    // alternate raw code 2'b11, d segment and dark dp
    wr(3'd2, 8'h81);
    fmt = 2'b11;
    repeat (2) @(negedge clk);
    wait_digit(2, s);
    check("R5 raw alt code d segment", s, 8'h08);
  endtask

  task automatic test_decode(input logic [1:0] f, input string req);
    logic [7:0] s;
    fmt = f;
    for (int base = 0; base < 16; base += 8) begin
      for (int i = 0; i < 8; i++) wr(3'(i), 8'(base + i));
      repeat (2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        logic [3:0] n;
        n = 4'(base + i);
        wait_digit(i, s);
        check($sformatf("%s value %0d", req, n), s,
              {1'b0, (f == 2'b01) ? exp_hex(n) : exp_codeb(n)});
      end
    end
  endtask

  task automatic test_dp_decoded();
    logic [7:0] s;
    fmt = 2'b01;
    wr(3'd4, 8'hF3);
    wr(3'd5, 8'h73);
    repeat (2) @(negedge clk);
    wait_digit(4, s);
    check("R8 hex dp lit, bits 6..4 ignored", s, 8'hCF);
    wait_digit(5, s);
    check("R8 hex dp dark, bits 6..4 ignored", s, 8'h4F);
    fmt = 2'b10;
    wr(3'd6, 8'hBA);
    repeat (2) @(negedge clk);
    wait_digit(6, s);
    check("R8 code B dp with minus", s, 8'hC0);
  endtask

  task automatic measure(input int d);
    logic [7:0] s;
    int on_len, off_len;
    logic [7:0] nxt;
    wait_digit(d, s);
    on_len = 1;
    forever begin
      @(negedge clk);
      if (dig != (8'b1 << d)) break;
      on_len++;
    end
    off_len = 0;
    while (dig == 8'h00) begin
      check("R4 segments dark in gap", seg, 8'h00);
      off_len++;
      @(negedge clk);
    end
    nxt = 8'b1 << ((d + 1) % 8);
    check($sformatf("R3 dwell digit %0d", d), 8'(on_len), 8'(DWELL));
    check($sformatf("R4 gap after digit %0d", d), 8'(off_len), 8'(BLANK));
    check($sformatf("R2 strobe after digit %0d", d), dig, nxt);
  endtask

  task automatic test_timing();
    measure(2);
    measure(7);
  endtask

  task automatic test_shutdown();
    logic [7:0] s;
    fmt = 2'b01;
    wr(3'd5, 8'h01);
    repeat (2) @(negedge clk);
    wait_digit(5, s);
    shdn = 1'b1;
    @(negedge clk);
    check("R9 strobes off in shutdown", dig, 8'h00);
    check("R9 segments off in shutdown", seg, 8'h00);
    wr(3'd5, 8'h09);
    repeat (40) @(negedge clk);
    check("R9 still dark after long shutdown", dig, 8'h00);
    shdn = 1'b0;
    @(negedge clk);
    check("R9 resume same digit", dig, 8'h20);
    check("R10 write in shutdown shown", seg, 8'h6F);
  endtask

  task automatic test_tick_freeze();
    logic [7:0] s;
    wait_digit(1, s);
    tick = 1'b0;
    repeat (3 * DWELL) @(negedge clk);
    check("R11 strobe frozen without tick", dig, 8'h02);
    tick = 1'b1;
  endtask

  task automatic test_write_latency();
    logic [7:0] s;
    fmt = 2'b01;
    wait_digit(3, s);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h0E;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    check("R12 live write strobe", dig, 8'h08);
    check("R12 live write visible", seg, 8'h79);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    test_reset();
    repeat (3) @(negedge clk);
    test_raw();
    test_decode(2'b01, "R6 hex");
    test_decode(2'b10, "R7 code B");
    test_dp_decoded();
    test_timing();
    test_shutdown();
    test_tick_freeze();
    test_write_latency();
    summary();
    $finish;
  end

endmodule